// File: doc/BRIEF.md
# IDE DMA Sector Progress Tracker

This block follows the progress of one disk command whose data moves through a descriptor-driven DMA engine. A command is loaded with its mode, direction and starting position. Disk mode counts 512-byte sectors. Packet mode counts 2048-byte blocks and keeps a byte offset inside the current block. The DMA engine then kicks the tracker with the length and address of the bytes its descriptor still holds. The tracker takes all of those bytes as one chunk. It issues a single request to the backing store, naming the 512-byte sector where the chunk starts. It then waits for that store to finish.

When a chunk finishes, the tracker moves the position forward and lowers the remaining count. Once the command's count is used up, it sets a completion status and raises its interrupt. It pulses end-of-DMA when no descriptor bytes are left. A failure in the backing store ends the DMA at once with an error status. If a request cannot be launched because the medium is absent, the error is reported without a request. In packet mode that error also carries not-ready sense data.

Top module: `ide_xfer_tracker`

## Requirements
- R1: After reset, status is 0x00, irq is 0, sense key and code are 0, req_valid, dma_end and xfer_busy are 0.
- R2: In disk mode, a chunk of N bytes that completes without error adds (N+511)>>9 to cur_sector and subtracts the same value from sectors_left.
- R3: Whenever sectors_left (disk mode) is zero at a kick or after a completed chunk, status becomes 0x50 (ready plus seek-complete) and irq goes to 1. Loading a command with cmd_start clears irq and sets status to 0x80 (busy).
- R4: In packet mode, a completed chunk of N bytes adds N to byte_idx. (byte_idx+N)>>11 is added to cur_lba, and byte_idx keeps the low 11 bits of the sum.
- R5: In packet mode, req_sector of a launched request equals cur_lba*4 + (byte_idx>>9).
- R6: In packet mode, a completed chunk lowers pkt_left (two's complement, 25 bits) by N. When pkt_left is zero or negative, status becomes 0x50 and irq goes to 1.
- R7: A kick with dma_len of 0 gives a one-cycle dma_end on the next cycle and no request.
- R8: A kick with non-zero dma_len and media_ok gives req_valid for exactly one cycle on the next cycle. It sets req_addr = dma_addr, req_len = dma_len and next_addr = dma_addr + dma_len. The matching st_done gives a one-cycle dma_end on the following cycle.
- R9: st_done together with st_err sets status to 0x51, raises irq and pulses dma_end. cur_sector, sectors_left, cur_lba, byte_idx and pkt_left stay unchanged.
- R10: A kick with non-zero length while media_ok is 0 issues no request. It sets status 0x51, raises irq and pulses dma_end. In packet mode it also sets sense_key 0x2 and sense_code 0x3A.
- R11: The first kick after a command start makes no position update: req_sector equals the loaded start position.
- R12: req_write equals the direction latched by cmd_start in disk mode, and is always 0 in packet mode.
- R13: While a request is outstanding (xfer_busy is 1), cmd_start and dma_go have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Load a new command (ignored while busy) |
| cmd_packet | input | 1 | 1 = packet mode, 0 = disk mode |
| cmd_write | input | 1 | Direction, 1 = write (disk mode only) |
| cmd_sector | input | 28 | Disk start sector |
| cmd_count | input | 16 | Disk sector count |
| cmd_lba | input | 32 | Packet start block |
| cmd_pkt_bytes | input | 24 | Packet byte count |
| dma_go | input | 1 | DMA kick |
| dma_len | input | 16 | Descriptor bytes remaining |
| dma_addr | input | 32 | Descriptor buffer address |
| media_ok | input | 1 | Backing store can accept a request |
| st_done | input | 1 | Backing store finished the request |
| st_err | input | 1 | Qualifies st_done as failed |
| req_valid | output | 1 | One-cycle request to the backing store |
| req_write | output | 1 | Request direction |
| req_sector | output | 34 | 512-byte sector of the request |
| req_addr | output | 32 | Buffer address of the request |
| req_len | output | 16 | Byte length of the request |
| next_addr | output | 32 | Descriptor address after the chunk |
| dma_end | output | 1 | One-cycle end-of-DMA |
| xfer_busy | output | 1 | Request outstanding |
| irq | output | 1 | Device interrupt level |
| status | output | 8 | Device status byte |
| sense_key | output | 4 | Packet sense key |
| sense_code | output | 8 | Packet additional sense code |
| cur_sector | output | 28 | Disk position |
| sectors_left | output | 16 | Disk sectors remaining |
| cur_lba | output | 32 | Packet block position |
| byte_idx | output | 11 | Packet byte offset in block |
| pkt_left | output | 25 | Packet bytes remaining (signed) |

## Verification
Disk chunks are swept across lengths on either side of 512-byte multiples, such as 1, 511, 513 and 65535. A floor in place of the rounding up, or an off-by-one, would leave the sector position wrong by one. Packet chunks with odd sizes are run in a row so that the byte offset crosses 2048 again and again. A design that dropped the carry or did not mask the offset would report the wrong block and the wrong request sector. Completion is tested at an exact zero, at an overshoot into negative byte counts, and with a command that starts at a count of zero. The error and missing-medium paths are checked to confirm that the position stays the same and that no request leaks out.

// File: rtl/ide_trk_pkg.sv
package ide_trk_pkg;
    typedef enum logic {
        TRK_IDLE = 1'b0,
        TRK_WAIT = 1'b1
    } trk_state_e;

    localparam logic [7:0] STAT_BUSY = 8'h80;
    localparam logic [7:0] STAT_OK   = 8'h50;
    localparam logic [7:0] STAT_ERR  = 8'h51;

    localparam logic [3:0] SENSE_NOT_READY = 4'h2;
    localparam logic [7:0] ASC_NO_MEDIUM   = 8'h3A;
endpackage

// File: rtl/ide_disk_step.sv
module ide_disk_step #(
    parameter int LEN_W     = 16,
    parameter int CNT_W     = 16,
    parameter int SEC_SHIFT = 9
) (
    input  logic [LEN_W-1:0] len,
    output logic [CNT_W-1:0] nsec
);
    localparam logic [LEN_W:0] ROUND = (LEN_W+1)'((1 << SEC_SHIFT) - 1);

    logic [LEN_W:0] sum;

    always_comb begin
        sum  = {1'b0, len} + ROUND;
        nsec = CNT_W'(sum >> SEC_SHIFT);
    end
endmodule

// File: rtl/ide_pkt_step.sv
module ide_pkt_step #(
    parameter int LEN_W     = 16,
    parameter int LBA_W     = 32,
    parameter int BLK_SHIFT = 11,
    parameter int SEC_SHIFT = 9,
    parameter int RS_W      = LBA_W + BLK_SHIFT - SEC_SHIFT
) (
    input  logic [LBA_W-1:0]     lba,
    input  logic [BLK_SHIFT-1:0] idx,
    input  logic [LEN_W-1:0]     len,
    output logic [LBA_W-1:0]     lba_next,
    output logic [BLK_SHIFT-1:0] idx_next,
    output logic [RS_W-1:0]      sect
);
    localparam int SUB = BLK_SHIFT - SEC_SHIFT;

    logic [LEN_W:0] sum;

    always_comb begin
        sum      = (LEN_W+1)'(idx) + {1'b0, len};
        lba_next = lba + LBA_W'(sum >> BLK_SHIFT);
        idx_next = sum[BLK_SHIFT-1:0];
        sect     = (RS_W'(lba) << SUB) + RS_W'(idx >> SEC_SHIFT);
    end
endmodule

// File: rtl/ide_xfer_tracker.sv
module ide_xfer_tracker
    import ide_trk_pkg::*;
#(
    parameter int SEC_W     = 28,
    parameter int CNT_W     = 16,
    parameter int LBA_W     = 32,
    parameter int PB_W      = 24,
    parameter int LEN_W     = 16,
    parameter int ADDR_W    = 32,
    parameter int BLK_SHIFT = 11,
    parameter int SEC_SHIFT = 9,
    localparam int PL_W     = PB_W + 1,
    localparam int RS_W     = LBA_W + BLK_SHIFT - SEC_SHIFT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_start,
    input  logic                 cmd_packet,
    input  logic                 cmd_write,
    input  logic [SEC_W-1:0]     cmd_sector,
    input  logic [CNT_W-1:0]     cmd_count,
    input  logic [LBA_W-1:0]     cmd_lba,
    input  logic [PB_W-1:0]      cmd_pkt_bytes,
    input  logic                 dma_go,
    input  logic [LEN_W-1:0]     dma_len,
    input  logic [ADDR_W-1:0]    dma_addr,
    input  logic                 media_ok,
    input  logic                 st_done,
    input  logic                 st_err,
    output logic                 req_valid,
    output logic                 req_write,
    output logic [RS_W-1:0]      req_sector,
    output logic [ADDR_W-1:0]    req_addr,
    output logic [LEN_W-1:0]     req_len,
    output logic [ADDR_W-1:0]    next_addr,
    output logic                 dma_end,
    output logic                 xfer_busy,
    output logic                 irq,
    output logic [7:0]           status,
    output logic [3:0]           sense_key,
    output logic [7:0]           sense_code,
    output logic [SEC_W-1:0]     cur_sector,
    output logic [CNT_W-1:0]     sectors_left,
    output logic [LBA_W-1:0]     cur_lba,
    output logic [BLK_SHIFT-1:0] byte_idx,
    output logic [PL_W-1:0]      pkt_left
);
    typedef struct packed {
        trk_state_e          st;
        logic                pkt;
        logic                wr;
        logic [SEC_W-1:0]    sector;
        logic [CNT_W-1:0]    left;
        logic [LBA_W-1:0]    lba;
        logic [BLK_SHIFT-1:0] idx;
        logic [PL_W-1:0]     pleft;
        logic [LEN_W-1:0]    chunk;
        logic [7:0]          status;
        logic [3:0]          skey;
        logic [7:0]          asc;
        logic                irq;
        logic                dma_end;
        logic                req_valid;
        logic                req_write;
        logic [RS_W-1:0]     req_sector;
        logic [ADDR_W-1:0]   req_addr;
        logic [LEN_W-1:0]    req_len;
        logic [ADDR_W-1:0]   next_addr;
    } trk_t;

    trk_t q, d;

    logic [CNT_W-1:0]     nsec;
    logic [LBA_W-1:0]     lba_nx;
    logic [BLK_SHIFT-1:0] idx_nx;
    logic [RS_W-1:0]      pkt_sect;
    logic                 pkt_done_q;

    ide_disk_step #(
        .LEN_W(LEN_W), .CNT_W(CNT_W), .SEC_SHIFT(SEC_SHIFT)
    ) u_disk (
        .len (q.chunk),
        .nsec(nsec)
    );

    ide_pkt_step #(
        .LEN_W(LEN_W), .LBA_W(LBA_W), .BLK_SHIFT(BLK_SHIFT),
        .SEC_SHIFT(SEC_SHIFT), .RS_W(RS_W)
    ) u_pkt (
        .lba     (q.lba),
        .idx     (q.idx),
        .len     (q.chunk),
        .lba_next(lba_nx),
        .idx_next(idx_nx),
        .sect    (pkt_sect)
    );

    assign pkt_done_q = q.pleft[PL_W-1] || (q.pleft == '0);

    always_comb begin
        d           = q;
        d.dma_end   = 1'b0;
        d.req_valid = 1'b0;
        if (q.st == TRK_IDLE) begin
            if (cmd_start) begin
                d.pkt    = cmd_packet;
                d.wr     = cmd_write;
                d.sector = cmd_sector;
                d.left   = cmd_count;
                d.lba    = cmd_lba;
                d.idx    = '0;
                d.pleft  = PL_W'(cmd_pkt_bytes);
                d.chunk  = '0;
                d.status = STAT_BUSY;
                d.skey   = '0;
                d.asc    = '0;
                d.irq    = 1'b0;
            end else if (dma_go) begin
                // entry with no prior chunk: only a completion check
                if (q.pkt ? pkt_done_q : (q.left == '0)) begin
                    d.status = STAT_OK;
                    d.irq    = 1'b1;
                end
                if (dma_len == '0) begin
                    d.dma_end = 1'b1;
                end else if (!media_ok) begin
                    d.status  = STAT_ERR;
                    d.irq     = 1'b1;
                    d.dma_end = 1'b1;
                    if (q.pkt) begin
                        d.skey = SENSE_NOT_READY;
                        d.asc  = ASC_NO_MEDIUM;
                    end
                end else begin
                    d.st         = TRK_WAIT;
                    d.chunk      = dma_len;
                    d.req_valid  = 1'b1;
                    d.req_write  = q.wr && !q.pkt;
                    d.req_sector = q.pkt ? pkt_sect : RS_W'(q.sector);
                    d.req_addr   = dma_addr;
                    d.req_len    = dma_len;
                    d.next_addr  = dma_addr + ADDR_W'(dma_len);
                end
            end
        end else if (st_done) begin
            d.st      = TRK_IDLE;
            d.dma_end = 1'b1;
            if (st_err) begin
                d.status = STAT_ERR;
                d.irq    = 1'b1;
            end else if (q.pkt) begin
                d.lba   = lba_nx;
                d.idx   = idx_nx;
                d.pleft = q.pleft - PL_W'(q.chunk);
                if (d.pleft[PL_W-1] || (d.pleft == '0)) begin
                    d.status = STAT_OK;
                    d.irq    = 1'b1;
                end
            end else begin
                d.sector = q.sector + SEC_W'(nsec);
                d.left   = q.left - nsec;
                if (d.left == '0) begin
                    d.status = STAT_OK;
                    d.irq    = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_valid    = q.req_valid;
    assign req_write    = q.req_write;
    assign req_sector   = q.req_sector;
    assign req_addr     = q.req_addr;
    assign req_len      = q.req_len;
    assign next_addr    = q.next_addr;
    assign dma_end      = q.dma_end;
    assign xfer_busy    = (q.st == TRK_WAIT);
    assign irq          = q.irq;
    assign status       = q.status;
    assign sense_key    = q.skey;
    assign sense_code   = q.asc;
    assign cur_sector   = q.sector;
    assign sectors_left = q.left;
    assign cur_lba      = q.lba;
    assign byte_idx     = q.idx;
    assign pkt_left     = q.pleft;
endmodule

// File: rtl/ide_xfer_tracker_chk.sv
module ide_xfer_tracker_chk #(
    parameter int SEC_W = 28,
    parameter int LBA_W = 32,
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic             dma_end,
    input logic             xfer_busy,
    input logic             irq,
    input logic [7:0]       status,
    input logic             st_done,
    input logic             st_err,
    input logic             dma_go,
    input logic             cmd_start,
    input logic [LEN_W-1:0] dma_len,
    input logic             media_ok,
    input logic             mode_pkt,
    input logic [SEC_W-1:0] cur_sector,
    input logic [LBA_W-1:0] cur_lba
);
    // R8
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R7
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && dma_end));

    // R12
    pkt_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_pkt) |-> !req_write);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && st_done && st_err) |=>
            (dma_end && status == 8'h51 && $stable(cur_sector) && $stable(cur_lba)));

    // R10
    no_media_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_busy && dma_go && !cmd_start && dma_len != '0 && !media_ok) |=>
            (!req_valid && dma_end && irq));

    // R3
    irq_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> status[6]);
endmodule

bind ide_xfer_tracker ide_xfer_tracker_chk #(
    .SEC_W(SEC_W), .LBA_W(LBA_W), .LEN_W(LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .dma_end   (dma_end),
    .xfer_busy (xfer_busy),
    .irq       (irq),
    .status    (status),
    .st_done   (st_done),
    .st_err    (st_err),
    .dma_go    (dma_go),
    .cmd_start (cmd_start),
    .dma_len   (dma_len),
    .media_ok  (media_ok),
    .mode_pkt  (q.pkt),
    .cur_sector(cur_sector),
    .cur_lba   (cur_lba)
);

// File: tb/ide_xfer_tracker_tb.sv
module ide_xfer_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 0, cmd_packet = 0, cmd_write = 0;
    logic [27:0] cmd_sector = '0;
    logic [15:0] cmd_count = '0;
    logic [31:0] cmd_lba = '0;
    logic [23:0] cmd_pkt_bytes = '0;
    logic        dma_go = 0;
    logic [15:0] dma_len = '0;
    logic [31:0] dma_addr = '0;
    logic        media_ok = 1;
    logic        st_done = 0, st_err = 0;
    logic        req_valid, req_write, dma_end, xfer_busy, irq;
    logic [33:0] req_sector;
    logic [31:0] req_addr, next_addr;
    logic [15:0] req_len;
    logic [7:0]  status, sense_code;
    logic [3:0]  sense_key;
    logic [27:0] cur_sector;
    logic [15:0] sectors_left;
    logic [31:0] cur_lba;
    logic [10:0] byte_idx;
    logic [24:0] pkt_left;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ide_xfer_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_packet(cmd_packet),
        .cmd_write(cmd_write), .cmd_sector(cmd_sector), .cmd_count(cmd_count),
        .cmd_lba(cmd_lba), .cmd_pkt_bytes(cmd_pkt_bytes), .dma_go(dma_go),
        .dma_len(dma_len), .dma_addr(dma_addr), .media_ok(media_ok),
        .st_done(st_done), .st_err(st_err), .req_valid(req_valid),
        .req_write(req_write), .req_sector(req_sector), .req_addr(req_addr),
        .req_len(req_len), .next_addr(next_addr), .dma_end(dma_end),
        .xfer_busy(xfer_busy), .irq(irq), .status(status), .sense_key(sense_key),
        .sense_code(sense_code), .cur_sector(cur_sector), .sectors_left(sectors_left),
        .cur_lba(cur_lba), .byte_idx(byte_idx), .pkt_left(pkt_left)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic start_cmd(input logic pkt, input logic wr, input longint sec,
                             input longint cnt, input longint lba, input longint pb);
        cmd_start = 1; cmd_packet = pkt; cmd_write = wr;
        cmd_sector = 28'(sec); cmd_count = 16'(cnt); cmd_lba = 32'(lba);
        cmd_pkt_bytes = 24'(pb);
        @(negedge clk);
        cmd_start = 0;
    endtask

    task automatic go(input longint addr, input longint len);
        dma_go = 1; dma_addr = 32'(addr); dma_len = 16'(len);
        @(negedge clk);
        dma_go = 0;
    endtask

    task automatic done(input logic err);
        st_done = 1; st_err = err;
        @(negedge clk);
        st_done = 0; st_err = 0;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        longint lens[9] = '{1, 511, 512, 513, 1023, 1024, 1536, 4096, 65535};
        longint plens[7] = '{100, 2000, 2048, 300, 5000, 1, 4095};
        longint sec, n, lba_m, idx_m, pl_m, sum;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", status, 0);
        chk("R1 irq", irq, 0);
        chk("R1 req_valid", req_valid, 0);
        chk("R1 dma_end", dma_end, 0);
        chk("R1 busy", xfer_busy, 0);
        chk("R1 sense", {sense_key, sense_code}, 0);

        // R2 R8 R11 R12 disk sweep
        foreach (lens[i]) begin
            sec = 1000 + i * 7;
            n = (lens[i] + 511) >> 9;
            start_cmd(0, 1'(i % 2), sec, 200, 0, 0);
            chk("R3 start status", status, 8'h80);
            go(32'h1000 + i * 16, lens[i]);
            chk("R11 req_sector first", req_sector, sec);
            chk("R8 req_valid", req_valid, 1);
            chk("R8 req_addr", req_addr, 32'h1000 + i * 16);
            chk("R8 req_len", req_len, lens[i]);
            chk("R8 next_addr", next_addr, 32'h1000 + i * 16 + lens[i]);
            chk("R12 req_write disk", req_write, i % 2);
            chk("R11 no update", cur_sector, sec);
            done(0);
            chk("R8 req_valid one cycle", req_valid, 0);
            chk("R8 dma_end", dma_end, 1);
            chk("R2 sector", cur_sector, sec + n);
            chk("R2 left", sectors_left, 200 - n);
            chk("R3 not done irq", irq, 0);
            @(negedge clk);
            chk("R8 dma_end one cycle", dma_end, 0);
        end

        // R3 disk completion at exact zero
        start_cmd(0, 0, 50, 3, 0, 0);
        go(0, 1024); done(0);
        chk("R2 left 1", sectors_left, 1);
        chk("R3 irq low", irq, 0);
        go(0, 512); done(0);
        chk("R3 left 0", sectors_left, 0);
        chk("R3 status ok", status, 8'h50);
        chk("R3 irq", irq, 1);
        start_cmd(0, 0, 50, 3, 0, 0);
        chk("R3 start clears irq", irq, 0);

        // R7 R3 zero count, zero length kick
        start_cmd(0, 0, 9, 0, 0, 0);
        go(0, 0);
        chk("R7 dma_end", dma_end, 1);
        chk("R7 no req", req_valid, 0);
        chk("R3 zero count status", status, 8'h50);
        chk("R3 zero count irq", irq, 1);

        // R4 R5 R6 R12 packet sweep
        lba_m = 50; idx_m = 0; pl_m = 20000;
        start_cmd(1, 1, 0, 0, lba_m, pl_m);
        foreach (plens[i]) begin
            go(32'h8000, plens[i]);
            chk("R5 req_sector", req_sector, lba_m * 4 + (idx_m >> 9));
            chk("R12 packet read only", req_write, 0);
            done(0);
            sum = idx_m + plens[i];
            lba_m += sum >> 11;
            idx_m = sum & 2047;
            pl_m -= plens[i];
            chk("R4 lba", cur_lba, lba_m);
            chk("R4 byte_idx", byte_idx, idx_m);
            chk("R6 pkt_left", pkt_left, pl_m & 25'h1FFFFFF);
            chk("R6 not done", irq, 0);
        end
        go(0, 8000);
        chk("R5 req_sector last", req_sector, lba_m * 4 + (idx_m >> 9));
        done(0);
        pl_m -= 8000;
        chk("R6 negative left", pkt_left, pl_m & 25'h1FFFFFF);
        chk("R6 status ok", status, 8'h50);
        chk("R6 irq", irq, 1);

        // R6 exact zero
        start_cmd(1, 0, 0, 0, 7, 2048);
        go(0, 2048); done(0);
        chk("R6 exact zero left", pkt_left, 0);
        chk("R4 exact carry lba", cur_lba, 8);
        chk("R4 exact carry idx", byte_idx, 0);
        chk("R6 exact zero irq", irq, 1);

        // R9 error keeps position
        start_cmd(0, 0, 300, 10, 0, 0);
        go(0, 1024);
        done(1);
        chk("R9 status", status, 8'h51);
        chk("R9 irq", irq, 1);
        chk("R9 dma_end", dma_end, 1);
        chk("R9 sector kept", cur_sector, 300);
        chk("R9 left kept", sectors_left, 10);
        start_cmd(1, 0, 0, 0, 40, 9000);
        go(0, 700); done(1);
        chk("R9 pkt lba kept", cur_lba, 40);
        chk("R9 pkt idx kept", byte_idx, 0);
        chk("R9 pkt left kept", pkt_left, 9000);

        // R10 no medium
        media_ok = 0;
        start_cmd(1, 0, 0, 0, 40, 9000);
        go(0, 512);
        chk("R10 no req", req_valid, 0);
        chk("R10 dma_end", dma_end, 1);
        chk("R10 status", status, 8'h51);
        chk("R10 sense key", sense_key, 2);
        chk("R10 sense code", sense_code, 8'h3A);
        chk("R10 irq", irq, 1);
        start_cmd(0, 0, 5, 4, 0, 0);
        go(0, 512);
        chk("R10 disk no req", req_valid, 0);
        chk("R10 disk status", status, 8'h51);
        chk("R10 disk sense", sense_key, 0);
        media_ok = 1;

        // R13 ignored while busy
        start_cmd(0, 0, 600, 20, 0, 0);
        go(0, 512);
        chk("R13 busy", xfer_busy, 1);
        start_cmd(0, 0, 9999, 1, 0, 0);
        go(0, 4096);
        chk("R13 no second req", req_valid, 0);
        chk("R13 sector untouched", cur_sector, 600);
        chk("R13 count untouched", sectors_left, 20);
        done(0);
        chk("R13 sector after", cur_sector, 601);
        chk("R13 left after", sectors_left, 19);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule